// File: doc/BRIEF.md
# SCSI Initiator Status and Message Completion Sequencer

This block runs the closing steps of a SCSI command on the initiator side. On a command-complete request from the host it collects exactly one status byte and then exactly one message byte from the target. It returns the ACK/REQ handshake for each byte and writes each byte into the initiator's FIFO through a one-cycle write strobe. After the message byte it leaves ACK asserted. The host can then read the message and, if the message is not acceptable, raise ATN before the handshake is closed.

A second host command, message-accepted, closes that parked handshake by releasing ACK. When the target next asserts REQ, the block raises a service-request interrupt. The script stops early in two cases: when the target presents REQ in a phase the script does not expect, and when the target leaves the bus. Parity, data-phase transfers and the software decision to reject a message are handled elsewhere. The block only carries out the ATN set and clear requests it is given.

The bus inputs pass through a synchronizer of `SYNC_STAGES` flops before the sequencer uses them. Every bus reaction therefore lags the pins by that many cycles.

Top module: `scsi_cc_seq`

## Requirements
- R1: Command codes 0x11 and 0x91 both start the two-byte script with identical bus behaviour. Bit 7 (the DMA flag) makes no difference to the bytes, strobes or interrupts produced.
- R2: While the script waits for the status byte, REQ in the Status In phase (phase bits {MSG,C/D,I/O} = 3'b011) latches the data byte, gives one `fifo_wr_o` pulse with that byte and asserts ACK. ACK is dropped once REQ has gone low.
- R3: After the status byte, REQ in Message In (3'b111) writes the message byte to the FIFO and pulses `irq_done_o`. ACK is asserted and stays asserted until message-accepted or bus free.
- R4: REQ in any other phase at either step pulses `irq_svc_o`, writes nothing, leaves ACK low and ends the script.
- R5: Bus free (BSY low and SEL low) during the script, or while ACK is parked, pulses `irq_disc_o` and drops ACK and ATN.
- R6: Command code 0x12 releases ACK. The next REQ from the target then pulses `irq_svc_o`.
- R7: An `atn_set_i` pulse asserts ATN. If the pulse arrives while ACK is asserted, even in the same cycle as code 0x12, ATN is high for at least one cycle before ACK falls.
- R8: An `atn_clr_i` pulse drops ATN.
- R9: The following commands have no effect on ACK, ATN, FIFO writes or interrupts: codes other than 0x11, 0x91 and 0x12; any command while a script is running; and 0x11 or 0x91 while ACK is parked.
- R10: The three interrupt outputs are one-cycle pulses, and at most one of them is high in any cycle.
- R11: After reset, ACK, ATN, the FIFO strobe and all interrupts are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | One-cycle host command strobe |
| cmd_code_i | input | 8 | Host command code |
| atn_set_i | input | 1 | Host request to assert ATN |
| atn_clr_i | input | 1 | Host request to drop ATN |
| phase_i | input | 3 | Bus phase bits {MSG,C/D,I/O} |
| req_i | input | 1 | Target REQ |
| bsy_i | input | 1 | Bus BSY |
| sel_i | input | 1 | Bus SEL |
| data_i | input | DATA_W | Bus data byte |
| ack_o | output | 1 | Initiator ACK |
| atn_o | output | 1 | Initiator ATN |
| fifo_wr_o | output | 1 | FIFO write strobe |
| fifo_data_o | output | DATA_W | Byte written to the FIFO |
| irq_done_o | output | 1 | Successful-completion interrupt pulse |
| irq_svc_o | output | 1 | Service-request interrupt pulse |
| irq_disc_o | output | 1 | Disconnect interrupt pulse |

## Verification
The hardest situation to reach is an ATN request that lands while ACK is parked. The sharpest form is a request in the very cycle the message-accepted command is issued. The bench gets there by first running a full script with a target model that drops REQ and leaves ACK untouched, so ACK stays parked. It then drives the ATN request on the same clock as code 0x12 and records the level of ATN at the moment ACK falls. Bus free while ACK is parked is reached the same way: the bench lowers BSY after a completed script, with no command outstanding.

// File: rtl/scsi_cc_pkg.sv
package scsi_cc_pkg;

  localparam int PHASE_W = 3;

  localparam logic [PHASE_W-1:0] PH_STATUS = 3'b011;
  localparam logic [PHASE_W-1:0] PH_MSG_IN = 3'b111;

  localparam logic [6:0] OP_COMPLETE = 7'h11;
  localparam logic [7:0] OP_ACCEPT   = 8'h12;

  typedef enum logic [2:0] {
    S_IDLE,
    S_STAT_REQ,
    S_STAT_ACK,
    S_MSG_REQ,
    S_REL_HOLD,
    S_REL_WAIT
  } seq_state_e;

  typedef enum logic [1:0] {
    EV_NONE,
    EV_DONE,
    EV_SVC,
    EV_DISC
  } irq_ev_e;

  // The DMA flag in bit 7 selects no different script.
  function automatic logic is_complete_op(input logic [7:0] code);
    return code[6:0] == OP_COMPLETE;
  endfunction

  function automatic logic is_accept_op(input logic [7:0] code);
    return code == OP_ACCEPT;
  endfunction

  function automatic logic is_bus_free(input logic bsy, input logic sel);
    return !bsy && !sel;
  endfunction

endpackage

// File: rtl/scsi_cc_sync.sv
module scsi_cc_sync #(
  parameter int W      = 14,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= '0;
        else        stg[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= '0;
        else        stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/scsi_cc_busmon.sv
module scsi_cc_busmon
  import scsi_cc_pkg::*;
(
  input  logic [PHASE_W-1:0] phase,
  input  logic               req,
  input  logic               bsy,
  input  logic               sel,
  output logic               bus_free,
  output logic               req_hi,
  output logic               at_status,
  output logic               at_msg_in
);

  assign bus_free  = is_bus_free(bsy, sel);
  assign req_hi    = req && !bus_free;
  assign at_status = phase == PH_STATUS;
  assign at_msg_in = phase == PH_MSG_IN;

endmodule

// File: rtl/scsi_cc_fsm.sv
module scsi_cc_fsm
  import scsi_cc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_code,
  input  logic              atn_set,
  input  logic              atn_clr,
  input  logic              bus_free,
  input  logic              req_hi,
  input  logic              at_status,
  input  logic              at_msg_in,
  input  logic [DATA_W-1:0] bus_data,
  output logic              ack,
  output logic              atn,
  output logic              fifo_wr,
  output logic [DATA_W-1:0] fifo_data,
  output irq_ev_e           irq_ev,
  output logic              ack_hold,
  output logic              cc_start,
  output logic              accept_start
);

  seq_state_e state_q;
  logic       ack_q, atn_q, wr_q;
  logic [DATA_W-1:0] data_q;
  irq_ev_e    ev_q;

  logic drop_conn, take_status, take_msg, phase_miss, release_go, svc_go;

  assign ack_hold     = ack_q && (state_q == S_IDLE);
  assign cc_start     = cmd_valid && is_complete_op(cmd_code) &&
                        (state_q == S_IDLE) && !ack_q;
  assign accept_start = cmd_valid && is_accept_op(cmd_code) && (state_q == S_IDLE);

  assign drop_conn   = bus_free && ((state_q != S_IDLE) || ack_q);
  assign take_status = (state_q == S_STAT_REQ) && req_hi && at_status;
  assign take_msg    = (state_q == S_MSG_REQ) && req_hi && at_msg_in;
  assign phase_miss  = req_hi &&
                       (((state_q == S_STAT_REQ) && !at_status) ||
                        ((state_q == S_MSG_REQ)  && !at_msg_in));
  // A request to raise ATN in the release cycle holds ACK one more cycle.
  assign release_go  = (state_q == S_REL_HOLD) && !atn_set;
  assign svc_go      = (state_q == S_REL_WAIT) && req_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      atn_q <= 1'b0;
    end else if (drop_conn) begin
      atn_q <= 1'b0;
    end else if (atn_set) begin
      atn_q <= 1'b1;
    end else if (atn_clr) begin
      atn_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      ack_q   <= 1'b0;
      wr_q    <= 1'b0;
      data_q  <= '0;
      ev_q    <= EV_NONE;
    end else begin
      wr_q <= 1'b0;
      ev_q <= EV_NONE;
      if (drop_conn) begin
        state_q <= S_IDLE;
        ack_q   <= 1'b0;
        ev_q    <= EV_DISC;
      end else begin
        unique case (state_q)
          S_IDLE: begin
            if (cc_start)          state_q <= S_STAT_REQ;
            else if (accept_start) state_q <= S_REL_HOLD;
          end
          S_STAT_REQ: begin
            if (take_status) begin
              wr_q    <= 1'b1;
              data_q  <= bus_data;
              ack_q   <= 1'b1;
              state_q <= S_STAT_ACK;
            end else if (phase_miss) begin
              ev_q    <= EV_SVC;
              state_q <= S_IDLE;
            end
          end
          S_STAT_ACK: begin
            if (!req_hi) begin
              ack_q   <= 1'b0;
              state_q <= S_MSG_REQ;
            end
          end
          S_MSG_REQ: begin
            if (take_msg) begin
              wr_q    <= 1'b1;
              data_q  <= bus_data;
              ack_q   <= 1'b1;
              ev_q    <= EV_DONE;
              state_q <= S_IDLE;
            end else if (phase_miss) begin
              ev_q    <= EV_SVC;
              state_q <= S_IDLE;
            end
          end
          S_REL_HOLD: begin
            if (release_go) begin
              ack_q   <= 1'b0;
              state_q <= S_REL_WAIT;
            end
          end
          S_REL_WAIT: begin
            if (svc_go) begin
              ev_q    <= EV_SVC;
              state_q <= S_IDLE;
            end
          end
          default: state_q <= S_IDLE;
        endcase
      end
    end
  end

  assign ack       = ack_q;
  assign atn       = atn_q;
  assign fifo_wr   = wr_q;
  assign fifo_data = data_q;
  assign irq_ev    = ev_q;

endmodule

// File: rtl/scsi_cc_seq.sv
module scsi_cc_seq
  import scsi_cc_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid_i,
  input  logic [7:0]        cmd_code_i,
  input  logic              atn_set_i,
  input  logic              atn_clr_i,
  input  logic [2:0]        phase_i,
  input  logic              req_i,
  input  logic              bsy_i,
  input  logic              sel_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              ack_o,
  output logic              atn_o,
  output logic              fifo_wr_o,
  output logic [DATA_W-1:0] fifo_data_o,
  output logic              irq_done_o,
  output logic              irq_svc_o,
  output logic              irq_disc_o
);

  localparam int BUS_W = PHASE_W + 3 + DATA_W;

  logic [BUS_W-1:0]   bus_raw, bus_s;
  logic [PHASE_W-1:0] phase_s;
  logic               req_s, bsy_s, sel_s;
  logic [DATA_W-1:0]  data_s;

  logic    bus_free_w, req_hi_w, at_status_w, at_msg_in_w;
  logic    ack_hold_w, cc_start_w, accept_start_w;
  irq_ev_e irq_ev_w;

  assign bus_raw = {phase_i, req_i, bsy_i, sel_i, data_i};

  scsi_cc_sync #(.W(BUS_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (bus_raw),
    .q     (bus_s)
  );

  assign {phase_s, req_s, bsy_s, sel_s, data_s} = bus_s;

  scsi_cc_busmon u_mon (
    .phase     (phase_s),
    .req       (req_s),
    .bsy       (bsy_s),
    .sel       (sel_s),
    .bus_free  (bus_free_w),
    .req_hi    (req_hi_w),
    .at_status (at_status_w),
    .at_msg_in (at_msg_in_w)
  );

  scsi_cc_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid_i),
    .cmd_code     (cmd_code_i),
    .atn_set      (atn_set_i),
    .atn_clr      (atn_clr_i),
    .bus_free     (bus_free_w),
    .req_hi       (req_hi_w),
    .at_status    (at_status_w),
    .at_msg_in    (at_msg_in_w),
    .bus_data     (data_s),
    .ack          (ack_o),
    .atn          (atn_o),
    .fifo_wr      (fifo_wr_o),
    .fifo_data    (fifo_data_o),
    .irq_ev       (irq_ev_w),
    .ack_hold     (ack_hold_w),
    .cc_start     (cc_start_w),
    .accept_start (accept_start_w)
  );

  assign irq_done_o = irq_ev_w == EV_DONE;
  assign irq_svc_o  = irq_ev_w == EV_SVC;
  assign irq_disc_o = irq_ev_w == EV_DISC;

endmodule

// File: rtl/scsi_cc_chk.sv
module scsi_cc_chk (
  input logic clk,
  input logic rst_n,
  input logic ack,
  input logic atn,
  input logic fifo_wr,
  input logic irq_done,
  input logic irq_svc,
  input logic irq_disc,
  input logic ack_hold,
  input logic bus_free,
  input logic cc_start,
  input logic atn_set
);

  logic [1:0] wr_cnt;
  logic       atn_req_q;
  logic       atn_req_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        wr_cnt <= '0;
    else if (cc_start) wr_cnt <= '0;
    else if (fifo_wr && wr_cnt != 2'd3) wr_cnt <= wr_cnt + 2'd1;
  end

  assign atn_req_seen = atn_req_q || (atn_set && ack);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   atn_req_q <= 1'b0;
    else if (!ack) atn_req_q <= 1'b0;
    else if (atn_set) atn_req_q <= 1'b1;
  end

  a_r10_one_irq: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_done, irq_svc, irq_disc}));

  a_r10_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_done || irq_svc || irq_disc) |=> !(irq_done || irq_svc || irq_disc));

  a_r2_write_acked: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> ack);

  a_r3_done_ack: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done |-> (ack && fifo_wr));

  a_r3_ack_parked: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_hold && !bus_free) |=> ack);

  a_r1_two_bytes: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done |-> (wr_cnt == 2'd1));

  a_r4_miss_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    irq_svc |-> (!fifo_wr && !ack));

  a_r5_disc_release: assert property (@(posedge clk) disable iff (!rst_n)
    irq_disc |-> (!ack && !atn));

  a_r7_atn_first: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ack) && !irq_disc && $past(atn_req_seen)) |-> $past(atn));

endmodule

bind scsi_cc_seq scsi_cc_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ack      (ack_o),
  .atn      (atn_o),
  .fifo_wr  (fifo_wr_o),
  .irq_done (irq_done_o),
  .irq_svc  (irq_svc_o),
  .irq_disc (irq_disc_o),
  .ack_hold (ack_hold_w),
  .bus_free (bus_free_w),
  .cc_start (cc_start_w),
  .atn_set  (atn_set_i)
);

// File: tb/scsi_cc_seq_test.sv
`timescale 1ns/1ps
module scsi_cc_seq_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid_i = 1'b0;
  logic [7:0] cmd_code_i = '0;
  logic       atn_set_i = 1'b0;
  logic       atn_clr_i = 1'b0;
  logic [2:0] phase_i = 3'b011;
  logic       req_i = 1'b0;
  logic       bsy_i = 1'b1;
  logic       sel_i = 1'b0;
  logic [7:0] data_i = '0;
  logic       ack_o, atn_o, fifo_wr_o, irq_done_o, irq_svc_o, irq_disc_o;
  logic [7:0] fifo_data_o;

  always #2 clk = ~clk;

  scsi_cc_seq uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid_i), .cmd_code_i(cmd_code_i),
    .atn_set_i(atn_set_i), .atn_clr_i(atn_clr_i), .phase_i(phase_i), .req_i(req_i),
    .bsy_i(bsy_i), .sel_i(sel_i), .data_i(data_i), .ack_o(ack_o), .atn_o(atn_o),
    .fifo_wr_o(fifo_wr_o), .fifo_data_o(fifo_data_o), .irq_done_o(irq_done_o),
    .irq_svc_o(irq_svc_o), .irq_disc_o(irq_disc_o)
  );

  // kinds: 0 FIFO byte, 1 done, 2 service, 3 disconnect
  typedef struct { int kind; int data; string req; } exp_t;
  exp_t exp_q[$];
  int checks = 0;
  int fails = 0;
  int cyc = 0;
  logic prev_ack = 1'b0;
  logic atn_at_fall = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push(input int kind, input int data, input string req);
    exp_t e;
    e.kind = kind; e.data = data; e.req = req;
    exp_q.push_back(e);
  endtask

  function automatic void observe(input int kind, input int data);
    exp_t e;
    checks++;
    if (exp_q.size() == 0) begin
      fails++;
      $display("FAIL R9 unexpected event: actual kind %0d data %0h expected none", kind, data);
    end else begin
      e = exp_q.pop_front();
      if (e.kind != kind || (kind == 0 && e.data != data)) begin
        fails++;
        $display("FAIL %s event: actual kind %0d data %0h expected kind %0d data %0h",
                 e.req, kind, data, e.kind, e.data);
      end
    end
  endfunction

  // Monitor: scoreboard comparison away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      if (fifo_wr_o)  observe(0, int'(fifo_data_o));
      if (irq_done_o) observe(1, 0);
      if (irq_svc_o)  observe(2, 0);
      if (irq_disc_o) observe(3, 0);
      if (prev_ack && !ack_o) atn_at_fall = atn_o;
      prev_ack = ack_o;
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      fails++;
      $display("FAIL R10 watchdog: actual %0d cycles expected fewer", cyc);
      summary();
      $finish;
    end
  end

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_cmd(input logic [7:0] code, input logic with_atn);
    @(negedge clk);
    cmd_valid_i = 1'b1; cmd_code_i = code; atn_set_i = with_atn;
    @(negedge clk);
    cmd_valid_i = 1'b0; atn_set_i = 1'b0;
  endtask

  task automatic pulse_atn(input bit set);
    @(negedge clk);
    if (set) atn_set_i = 1'b1; else atn_clr_i = 1'b1;
    @(negedge clk);
    atn_set_i = 1'b0; atn_clr_i = 1'b0;
  endtask

  task automatic wait_ack(input logic level);
    for (int i = 0; i < 50 && ack_o != level; i++) @(negedge clk);
  endtask

  // Target sends one byte with a full REQ/ACK handshake.
  task automatic tgt_byte(input logic [2:0] ph, input logic [7:0] d, input bit held);
    @(negedge clk);
    phase_i = ph; data_i = d;
    @(negedge clk);
    req_i = 1'b1;
    wait_ack(1'b1);
    @(negedge clk);
    req_i = 1'b0;
    if (!held) wait_ack(1'b0);
  endtask

  task automatic tgt_req(input logic [2:0] ph, input int n);
    @(negedge clk);
    phase_i = ph;
    @(negedge clk);
    req_i = 1'b1;
    settle(n);
    req_i = 1'b0;
  endtask

  initial begin
    settle(4);
    check(ack_o == 0 && atn_o == 0, "R11", "ack/atn in reset", {ack_o, atn_o}, 0);
    check({fifo_wr_o, irq_done_o, irq_svc_o, irq_disc_o} == 0, "R11", "strobes in reset",
          {fifo_wr_o, irq_done_o, irq_svc_o, irq_disc_o}, 0);
    rst_n = 1'b1;
    settle(4);
    check(ack_o == 0, "R11", "ack after reset", ack_o, 0);

    // Normal script with code 0x11, ACK parked after the message byte.
    push(0, 8'hA5, "R2"); push(0, 8'h00, "R3"); push(1, 0, "R3");
    send_cmd(8'h11, 1'b0);
    tgt_byte(3'b011, 8'hA5, 1'b0);
    tgt_byte(3'b111, 8'h00, 1'b1);
    settle(10);
    check(ack_o == 1, "R3", "ack parked after message", ack_o, 1);

    // Ignored commands while ACK is parked (R9).
    send_cmd(8'h13, 1'b0);
    send_cmd(8'h11, 1'b0);
    send_cmd(8'h91, 1'b0);
    settle(10);
    check(ack_o == 1, "R9", "ack after ignored codes", ack_o, 1);
    check(atn_o == 0, "R9", "atn after ignored codes", atn_o, 0);

    // ATN request while parked, then release (R7, R6, R8).
    pulse_atn(1'b1);
    settle(2);
    check(atn_o == 1, "R7", "atn after set request", atn_o, 1);
    check(ack_o == 1, "R7", "ack still parked", ack_o, 1);
    push(2, 0, "R6");
    send_cmd(8'h12, 1'b0);
    wait_ack(1'b0);
    settle(1);
    check(ack_o == 0, "R6", "ack released by 0x12", ack_o, 0);
    check(atn_at_fall == 1, "R7", "atn at ack fall", atn_at_fall, 1);
    tgt_req(3'b111, 6);
    settle(6);
    pulse_atn(1'b0);
    settle(3);
    check(atn_o == 0, "R8", "atn after clear request", atn_o, 0);

    // DMA variant 0x91, then ATN request in the same cycle as 0x12 (R1, R7).
    push(0, 8'h02, "R1"); push(0, 8'h04, "R1"); push(1, 0, "R1");
    send_cmd(8'h91, 1'b0);
    tgt_byte(3'b011, 8'h02, 1'b0);
    tgt_byte(3'b111, 8'h04, 1'b1);
    settle(6);
    check(ack_o == 1, "R1", "ack parked after 0x91", ack_o, 1);
    atn_at_fall = 1'b0;
    push(2, 0, "R6");
    send_cmd(8'h12, 1'b1);
    wait_ack(1'b0);
    settle(1);
    check(atn_at_fall == 1, "R7", "same-cycle atn at ack fall", atn_at_fall, 1);
    tgt_req(3'b111, 6);
    settle(6);
    pulse_atn(1'b0);
    settle(3);

    // Target skips Message In after status (R4).
    push(0, 8'h5A, "R2"); push(2, 0, "R4");
    send_cmd(8'h11, 1'b0);
    tgt_byte(3'b011, 8'h5A, 1'b0);
    tgt_req(3'b001, 10);
    settle(6);
    check(ack_o == 0, "R4", "ack after phase miss", ack_o, 0);

    // Wrong phase at the first byte (R4).
    push(2, 0, "R4");
    send_cmd(8'h11, 1'b0);
    tgt_req(3'b110, 10);
    settle(6);
    check(ack_o == 0, "R4", "ack after first-byte miss", ack_o, 0);

    // Disconnect mid-script with ATN up (R5).
    pulse_atn(1'b1);
    push(0, 8'h33, "R2"); push(3, 0, "R5");
    send_cmd(8'h11, 1'b0);
    tgt_byte(3'b011, 8'h33, 1'b0);
    @(negedge clk); bsy_i = 1'b0;
    settle(8);
    check(ack_o == 0, "R5", "ack after disconnect", ack_o, 0);
    check(atn_o == 0, "R5", "atn after disconnect", atn_o, 0);
    bsy_i = 1'b1;
    settle(6);

    // Disconnect while ACK is parked (R5).
    push(0, 8'h01, "R2"); push(0, 8'h07, "R3"); push(1, 0, "R3");
    send_cmd(8'h11, 1'b0);
    tgt_byte(3'b011, 8'h01, 1'b0);
    tgt_byte(3'b111, 8'h07, 1'b1);
    settle(6);
    push(3, 0, "R5");
    @(negedge clk); bsy_i = 1'b0;
    settle(8);
    check(ack_o == 0, "R5", "parked ack after disconnect", ack_o, 0);
    bsy_i = 1'b1;
    settle(6);

    // Commands issued while the script runs are ignored (R9).
    push(0, 8'h0C, "R9"); push(0, 8'h80, "R9"); push(1, 0, "R9");
    send_cmd(8'h11, 1'b0);
    settle(2);
    send_cmd(8'h12, 1'b0);
    send_cmd(8'h11, 1'b0);
    tgt_byte(3'b011, 8'h0C, 1'b0);
    send_cmd(8'h12, 1'b0);
    tgt_byte(3'b111, 8'h80, 1'b1);
    settle(6);
    check(ack_o == 1, "R9", "ack parked after busy commands", ack_o, 1);
    push(2, 0, "R6");
    send_cmd(8'h12, 1'b0);
    wait_ack(1'b0);
    tgt_req(3'b011, 6);
    settle(20);

    check(exp_q.size() == 0, "R10", "pending expected events", exp_q.size(), 0);
    summary();
    $finish;
  end

endmodule